// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block is the digital start-up controller for the reference DAC of a switching regulator. It stays idle until the supply power-on-reset flag and the enable input are both high. After a fixed settling delay it moves the DAC code up slowly to a fixed boot level. It then waits until the output-window comparator reports good for a run of consecutive PWM switching cycles. When that run is complete it drives the active-low clock-enable output low. From then on the DAC code moves at a faster rate toward the code on the VID pins, and it keeps following that code.

All timing is counted in microsecond ticks, which come in on a single-cycle strobe input. Both ramp rates come from a half-microsecond accumulator, so the fast slew can average 2.5 µs per code from a 1 µs time base. Power-good rises a fixed number of ticks after the sequence starts, but only once the clock enable has been granted. Losing either the power-on-reset flag or the enable input aborts the sequence at any point and returns the block to idle.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and for as long as por_ok or enable is low, dac_code is 0, clk_en_n is 1 and pgood is 0.
- R2: Once por_ok and enable are both high (in either order), 120 us_tick pulses pass as a settling delay. The slow ramp then starts, so dac_code first reads 1 right after the 125th tick counted from the start.
- R3: The slow ramp adds 2 to a half-microsecond accumulator on each tick. When the sum reaches 10 it steps dac_code up by one and subtracts 10. The accumulator is cleared when the ramp starts. The ramp stops at the boot code 88 (12.5 mV per code, 1.1 V).
- R4: Only while the block holds at the boot code, each pwm_cycle pulse with in_window high adds one to a run count, and a pulse with in_window low resets the count to 0. pwm_cycle pulses at any other time are ignored. On the 13th consecutive good pulse, clk_en_n goes low in the next cycle.
- R5: After clk_en_n falls, dac_code moves toward the target by one code each time the accumulator, again cleared on entry and adding 2 per tick, reaches 5. That threshold is subtracted and the remainder is kept. The k-th step therefore falls on tick ceil(2.5·k) after entry.
- R6: In the slew phase dac_code stays exactly at the target once it gets there. It follows later vid_code changes up or down at the R5 rate, one code per step.
- R7: The target is vid_code limited to the range 1 to 120 (12.5 mV to 1.5 V). Codes above 120 give 120 and code 0 gives 1.
- R8: pgood goes high one cycle after the 7000th tick counted from the start of the sequence, and only while clk_en_n is low.
- R9: If por_ok or enable falls at any time, then in the next cycle dac_code is 0, clk_en_n is 1 and pgood is 0. A later restart follows R2 again.
- R10: dac_code never changes by more than one code between cycles, except for the drop to 0 on abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Supply is above its power-on-reset threshold |
| enable | input | 1 | Regulator enable request |
| in_window | input | 1 | Output is within the boot-voltage window |
| pwm_cycle | input | 1 | One-cycle strobe per PWM switching cycle |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| vid_code | input | 8 | Requested voltage code, 12.5 mV per code |
| dac_code | output | 8 | Reference DAC code |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power good |

## Verification
The hardest condition to reach is the qualification gate with a broken run. The block must be holding at the boot code, and the window flag has to drop exactly once after twelve good cycles. Only a further full run of thirteen may then release the clock enable. The stimulus first lets the slow ramp finish. It then sends the pulses one at a time, each lined up away from tick edges, so the slew entry and the following steps can be timed to the exact tick. Power-good timing is checked by counting 7000 ticks from the start of the sequence. The abort path is exercised twice, once by dropping the enable during the slew and once by dropping the power-on-reset flag in the middle of a ramp.

// File: rtl/vrss_pkg.sv
package vrss_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RAMP,
        ST_QUAL,
        ST_SLEW
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [CODE_W-1:0]   dac;
        logic                clk_en_n;
        logic                pgood;
    } seq_regs_t;
endpackage

// File: rtl/vrss_us_timer.sv
module vrss_us_timer #(
    parameter int LIMIT = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick && (cnt_q != CW'(LIMIT)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(LIMIT));

    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done); // R8
endmodule

// File: rtl/vrss_rate_acc.sv
module vrss_rate_acc #(
    parameter int SLOW_HALF = 10,
    parameter int FAST_HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic fast,
    output logic step
);
    localparam int AW = $clog2(SLOW_HALF + FAST_HALF + 2) + 1;

    logic [AW-1:0] acc_d, acc_q, sum, thr;

    always_comb begin
        sum   = acc_q + AW'(2);
        thr   = fast ? AW'(FAST_HALF) : AW'(SLOW_HALF);
        step  = tick && !clear && (sum >= thr);
        acc_d = acc_q;
        if (clear)
            acc_d = '0;
        else if (tick)
            acc_d = step ? (sum - thr) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    AST_ACC_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(acc_q)); // R3
endmodule

// File: rtl/vrss_qual_cnt.sv
module vrss_qual_cnt #(
    parameter int NEED = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pwm,
    input  logic win,
    output logic met
);
    localparam int CW = $clog2(NEED + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        met   = active && pwm && win && (cnt_q == CW'(NEED - 1));
        cnt_d = cnt_q;
        if (!active || met)
            cnt_d = '0;
        else if (pwm)
            cnt_d = win ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_QUAL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vrss_pkg::*;
#(
    parameter int BOOT_CODE  = 88,
    parameter int MAX_CODE   = 120,
    parameter int MIN_CODE   = 1,
    parameter int DELAY_US   = 120,
    parameter int PGOOD_US   = 7000,
    parameter int QUAL_NEED  = 13,
    parameter int SLOW_HALF  = 10,
    parameter int FAST_HALF  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              enable,
    input  logic              in_window,
    input  logic              pwm_cycle,
    input  logic              us_tick,
    input  logic [CODE_W-1:0] vid_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              clk_en_n,
    output logic              pgood
);
    localparam logic [CODE_W-1:0] BOOT_C = CODE_W'(BOOT_CODE);
    localparam logic [CODE_W-1:0] MAX_C  = CODE_W'(MAX_CODE);
    localparam logic [CODE_W-1:0] MIN_C  = CODE_W'(MIN_CODE);

    seq_regs_t r_d, r_q;
    logic go, dly_done, pg_done, step, qual_met, acc_clear;
    logic [CODE_W-1:0] target;

    assign go = por_ok && enable;

    always_comb begin
        if (vid_code > MAX_C)      target = MAX_C;
        else if (vid_code < MIN_C) target = MIN_C;
        else                       target = vid_code;
    end

    vrss_us_timer #(.LIMIT(DELAY_US)) u_dly (
        .clk(clk), .rst_n(rst_n),
        .clear(r_q.state != ST_DELAY), .tick(us_tick), .done(dly_done)
    );

    vrss_us_timer #(.LIMIT(PGOOD_US)) u_pg (
        .clk(clk), .rst_n(rst_n),
        .clear(r_q.state == ST_IDLE), .tick(us_tick), .done(pg_done)
    );

    vrss_qual_cnt #(.NEED(QUAL_NEED)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .active(go && (r_q.state == ST_QUAL)),
        .pwm(pwm_cycle), .win(in_window), .met(qual_met)
    );

    vrss_rate_acc #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .clear(acc_clear), .tick(us_tick),
        .fast(r_q.state == ST_SLEW), .step(step)
    );

    always_comb begin
        r_d = r_q;
        if (!go) begin
            r_d.state    = ST_IDLE;
            r_d.dac      = '0;
            r_d.clk_en_n = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE:  r_d.state = ST_DELAY;
                ST_DELAY: if (dly_done) r_d.state = ST_RAMP;
                ST_RAMP: begin
                    if (r_q.dac == BOOT_C)  r_d.state = ST_QUAL;
                    else if (step)          r_d.dac   = r_q.dac + 1'b1;
                end
                ST_QUAL: begin
                    if (qual_met) begin
                        r_d.state    = ST_SLEW;
                        r_d.clk_en_n = 1'b0;
                    end
                end
                ST_SLEW: begin
                    if (step) begin
                        if (r_q.dac < target)      r_d.dac = r_q.dac + 1'b1;
                        else if (r_q.dac > target) r_d.dac = r_q.dac - 1'b1;
                    end
                end
                default:  r_d.state = ST_IDLE;
            endcase
        end
        r_d.pgood = (r_d.state == ST_SLEW) && pg_done;
        acc_clear = (r_d.state != r_q.state) || (r_q.state == ST_IDLE)
                    || (r_q.state == ST_DELAY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.dac      <= '0;
            r_q.clk_en_n <= 1'b1;
            r_q.pgood    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code = r_q.dac;
    assign clk_en_n = r_q.clk_en_n;
    assign pgood    = r_q.pgood;

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !(por_ok && enable) |=> (dac_code == '0 && clk_en_n && !pgood)); // R9
    AST_PGOOD_NEEDS_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> !clk_en_n); // R8
    AST_CLKEN_AT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_n) |-> (dac_code == BOOT_C && $past(pwm_cycle && in_window))); // R4
    AST_DAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code <= MAX_C); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code) && dac_code != '0) |->
        (dac_code == CODE_W'($past(dac_code) + 1'b1) ||
         CODE_W'(dac_code + 1'b1) == $past(dac_code))); // R10
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code) && dac_code != '0) |-> $past(us_tick)); // R3
endmodule

// File: tb/vr_softstart_seq_bench.sv
module vr_softstart_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_ok = 1'b0, enable = 1'b0, in_window = 1'b1, pwm_cycle = 1'b0;
    logic       us_tick = 1'b0;
    logic [7:0] vid_code = 8'd100;
    logic [7:0] dac_code;
    logic       clk_en_n, pgood;

    int n_chk = 0, n_err = 0;
    int tick_total = 0, tick_phase = 0;
    logic [1:0] div = 2'd0;
    logic [7:0] exp_q[$];
    logic [7:0] last_dac = 8'd0;

    vr_softstart_seq u_vr_softstart_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .enable(enable),
        .in_window(in_window), .pwm_cycle(pwm_cycle), .us_tick(us_tick),
        .vid_code(vid_code), .dac_code(dac_code), .clk_en_n(clk_en_n), .pgood(pgood)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        div     <= div + 2'd1;
        us_tick <= (div == 2'd3);
    end

    always @(posedge clk) begin
        if (us_tick) begin
            tick_total <= tick_total + 1;
            tick_phase <= tick_phase + 1;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // scoreboard monitor: every change of dac_code must match the next expected code
    always @(negedge clk) begin
        if (rst_n && dac_code != last_dac) begin
            if (exp_q.size() == 0) chk("R10 unexpected dac step", int'(dac_code), -1);
            else chk("R10 dac sequence", int'(dac_code), int'(exp_q.pop_front()));
            last_dac = dac_code;
        end
    end

    task automatic push_range(input int from, input int to);
        if (from <= to) for (int v = from; v <= to; v++) exp_q.push_back(8'(v));
        else            for (int v = from; v >= to; v--) exp_q.push_back(8'(v));
    endtask

    task automatic wait_safe();
        do begin @(negedge clk); #1; end while (us_tick);
    endtask

    task automatic wait_total(input int n);
        while (tick_total < n) @(negedge clk);
    endtask

    task automatic wait_phase(input int n);
        while (tick_phase < n) @(negedge clk);
    endtask

    task automatic pulse(input logic w);
        wait_safe();
        pwm_cycle = 1'b1;
        in_window = w;
        @(negedge clk); #1;
        pwm_cycle = 1'b0;
        in_window = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dac", dac_code, 0);
        chk("R1 reset clk_en_n", clk_en_n, 1);
        chk("R1 reset pgood", pgood, 0);

        // R1: por alone does not start
        por_ok = 1'b1;
        tick_phase = 0;
        wait_phase(200);
        chk("R1 no start without enable", dac_code, 0);
        chk("R1 clk_en_n idle", clk_en_n, 1);

        // Run 1: enable after por
        push_range(1, 88);
        wait_safe();
        enable = 1'b1;
        tick_total = 0;
        for (int i = 0; i < 13; i++) pulse(1'b1);   // R4: ignored in delay
        wait_total(124);
        chk("R2 still zero at tick 124", dac_code, 0);
        wait_total(125);
        chk("R2 first step at tick 125", dac_code, 1);
        wait_total(245);
        chk("R3 slow ramp code at tick 245", dac_code, 25);
        while (dac_code != 8'd88) @(negedge clk);
        chk("R3 boot reached at tick 560", tick_total, 560);
        chk("R4 pulses outside hold ignored", clk_en_n, 1);
        wait_total(600);
        chk("R3 ramp stops at boot", dac_code, 88);

        // R4 qualification with a broken run
        push_range(89, 100);
        vid_code = 8'd100;
        for (int i = 0; i < 12; i++) pulse(1'b1);
        pulse(1'b0);
        for (int i = 0; i < 12; i++) pulse(1'b1);
        chk("R4 broken run keeps clk_en_n high", clk_en_n, 1);
        pulse(1'b1);
        tick_phase = 0;
        chk("R4 clk_en_n low after 13 good", clk_en_n, 0);
        chk("R8 pgood low before delay", pgood, 0);
        wait_phase(2);
        chk("R5 no step before tick 3", dac_code, 88);
        wait_phase(3);
        chk("R5 first fast step at tick 3", dac_code, 89);
        wait_phase(29);
        chk("R5 code at tick 29", dac_code, 99);
        wait_phase(30);
        chk("R5 target at tick 30", dac_code, 100);
        wait_phase(60);
        chk("R6 holds at target", dac_code, 100);

        wait_total(7000);
        chk("R8 pgood low at tick 7000", pgood, 0);
        @(negedge clk);
        chk("R8 pgood high after tick 7000", pgood, 1);

        // R7 upper clamp, R6 follow up
        push_range(101, 120);
        vid_code = 8'd200;
        tick_phase = 0;
        wait_phase(100);
        chk("R7 clamp to 120", dac_code, 120);
        // R7 lower clamp, R6 follow down
        push_range(119, 1);
        vid_code = 8'd0;
        tick_phase = 0;
        wait_phase(320);
        chk("R7 clamp to 1", dac_code, 1);
        chk("R6 pgood stays high", pgood, 1);

        // R9 abort by enable
        exp_q.push_back(8'd0);
        wait_safe();
        enable = 1'b0;
        @(negedge clk);
        chk("R9 abort dac", dac_code, 0);
        chk("R9 abort clk_en_n", clk_en_n, 1);
        chk("R9 abort pgood", pgood, 0);

        // Run 2: enable tied high, por rises
        vid_code = 8'd100;
        por_ok = 1'b0;
        enable = 1'b1;
        repeat (10) @(negedge clk);
        push_range(1, 36);
        wait_safe();
        por_ok = 1'b1;
        tick_total = 0;
        wait_total(124);
        chk("R2 restart zero at 124", dac_code, 0);
        wait_total(125);
        chk("R2 restart first step", dac_code, 1);
        wait_total(300);
        chk("R3 code 36 at tick 300", dac_code, 36);
        exp_q.push_back(8'd0);
        wait_safe();
        por_ok = 1'b0;
        @(negedge clk);
        chk("R9 por loss dac", dac_code, 0);
        chk("R9 por loss clk_en_n", clk_en_n, 1);
        repeat (20) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule